// File: doc/BRIEF.md
# Integer Accumulator Command Unit

This block is a 32-bit integer accumulator that sits next to a bank of 256 resident 32-bit registers. An 8-bit host drives it. The host starts an operation with a single byte write to a command address. The address picks the operation. The byte is then used in one of three ways: as a register index, as a small literal (a shift count or a carry value), or not at all. The host never moves whole 32-bit operands to do arithmetic: operands stay in the register bank and are named by index, the way an 8-bit accumulator names zero-page cells.

The operations are load, store and swap between the accumulator and a register; add and subtract, each with and without carry; reverse subtract; compare; negate; AND, OR and XOR; logical and arithmetic shifts; rotate; signed and unsigned minimum and maximum; and absolute value. Carry follows the 8-bit convention: on subtraction, a carry of 1 means no borrow. A status byte reports the flags, a busy bit and a sticky error bit. A byte-wide transfer path lets the host fill any register from four byte writes, or read any register back as four bytes.

The bus is a plain register-style port. It has no valid/ready pair. Each write takes effect at the clock edge where it is seen. A write that arrives while the unit is busy is the only back-pressure: the unit drops it and records an error.

Top module: `acu_top`

## Requirements
- R1: Command `LOAD` (address 0) sets A to Reg[byte]. Command `STORE` (address 1) writes A into Reg[byte] and leaves the flags unchanged. Command `SWAP` (address 2) exchanges A and Reg[byte] within one command.
- R2: Command `ADD` (address 3) sets A to A+Reg. Command `ADDC` (address 4) sets A to A+Reg+C. For both, C becomes the carry out of bit 31 and V becomes the signed overflow.
- R3: Command `SUB` (address 5) computes A−Reg. Command `SUBC` (address 6) computes A−Reg−(1−C). Command `RSUB` (address 7) computes Reg−A. Command `CMP` (address 8) computes A−Reg but only updates the flags, leaving A unchanged. For all four, C=1 means no borrow, and V is the signed overflow.
- R4: Command `SETC` (address 9) loads C from bit 0 of the byte. It leaves A, Z, N and V unchanged.
- R5: Command `NEG` (address 10) sets A to 0−A, with C=1 only when A was 0 and V=1 only when A was 0x80000000. Command `ABS` (address 22) replaces A with its absolute value, sets V only for 0x80000000 and keeps C.
- R6: Commands `AND`, `OR` and `XOR` (addresses 11, 12, 13) combine A with Reg bitwise, clear V and keep C.
- R7: Commands `SHL`, `SHR`, `SSHR` and `ROL` (addresses 14, 15, 16, 17) shift left logically, shift right logically, shift right arithmetically, and rotate left. The count is bits 4:0 of the byte. C becomes the last bit shifted out (for rotate, the new bit 0) and V is kept. A count of 0 leaves A and C unchanged.
- R8: Commands `UMIN`, `SMIN`, `UMAX` and `SMAX` (addresses 18, 19, 20, 21) replace A with the unsigned or signed minimum or maximum of A and Reg. They clear V and keep C.
- R9: Z (result is zero) and N (bit 31 of the result) are updated by every command that produces a result. `CMP` updates them from the difference. `STORE`, `SETC` and the transfer commands leave them unchanged.
- R10: Reading address 0 returns the status byte {N, V, error, busy, 0, 0, Z, C}, from bit 7 down to bit 0.
- R11: After each accepted write, busy reads 1 for exactly one cycle. A write during that cycle is dropped and sets the error bit. The error bit stays set until the host reads status, which clears it.
- R12: Transfer port. Write 24 selects a register and copies it into a 32-bit stage. Write 25 shifts a byte into the top of the stage (stage = {byte, stage[31:8]}), so four writes fill it least significant byte first. Write 26 stores the stage into the selected register. Reads of addresses 1 to 4 return stage bytes 0 to 3.
- R13: After reset, A, all flags, busy, error and the stage are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one command per cycle |
| bus_rd | input | 1 | Read strobe; a status read clears the error bit |
| bus_addr | input | 5 | Command or read address |
| bus_wdata | input | 8 | Register index, literal, or unused byte |
| bus_rdata | output | 8 | Read data: status or stage byte (combinational) |

## Verification
The bench aims at these corner cases:
- Carry-chain edges. An adder that inverts the borrow sense, or drops the carry input on ADDC and SUBC, fails the flag compare after almost every subtract.
- Negating 0x80000000, and taking the absolute value of the same value. A missing overflow flag shows up in V.
- Shift and rotate counts of 0 and 32. A design that uses all eight bits of the count, or that clears C when nothing moves, changes A or C.
- A second write during the busy cycle. A design that accepts it changes A. A design that fails to latch the error, or to clear it on read, shows the wrong status byte on two reads in a row.

// File: rtl/acu_pkg.sv
package acu_pkg;
  typedef enum logic [4:0] {
    OP_LOAD  = 5'd0,  OP_STORE = 5'd1,  OP_SWAP  = 5'd2,
    OP_ADD   = 5'd3,  OP_ADDC  = 5'd4,  OP_SUB   = 5'd5,
    OP_SUBC  = 5'd6,  OP_RSUB  = 5'd7,  OP_CMP   = 5'd8,
    OP_SETC  = 5'd9,  OP_NEG   = 5'd10, OP_AND   = 5'd11,
    OP_OR    = 5'd12, OP_XOR   = 5'd13, OP_SHL   = 5'd14,
    OP_SHR   = 5'd15, OP_SSHR  = 5'd16, OP_ROL   = 5'd17,
    OP_UMIN  = 5'd18, OP_SMIN  = 5'd19, OP_UMAX  = 5'd20,
    OP_SMAX  = 5'd21, OP_ABS   = 5'd22, OP_NOP   = 5'd23,
    OP_XSEL  = 5'd24, OP_XPUT  = 5'd25, OP_XSAVE = 5'd26,
    OP_R27   = 5'd27, OP_R28   = 5'd28, OP_R29   = 5'd29,
    OP_R30   = 5'd30, OP_R31   = 5'd31
  } acu_op_e;

  localparam int ST_C    = 0;
  localparam int ST_Z    = 1;
  localparam int ST_BUSY = 4;
  localparam int ST_ERR  = 5;
  localparam int ST_V    = 6;
  localparam int ST_N    = 7;
endpackage

// File: rtl/acu_regfile.sv
module acu_regfile #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/acu_alu.sv
module acu_alu
  import acu_pkg::*;
#(
  parameter int W = 32,
  localparam int SHW = $clog2(W)
) (
  input  acu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] r,
  input  logic [7:0]   lit,
  input  logic         c_in,
  input  logic         v_in,
  output logic [W-1:0] res,
  output logic         a_we,
  output logic [W-1:0] fval,
  output logic         zn_we,
  output logic         c_out,
  output logic         v_out
);
  logic [W-1:0]   ax, ay;
  logic           aci;
  logic [W:0]     sum;
  logic           ovf;
  logic [SHW-1:0] sh;
  logic [2*W-1:0] rot;
  logic [W:0]     shl_w, shr_w, sshr_w;
  logic           ult, slt;
  localparam logic [W-1:0] SMIN_VAL = {1'b1, {(W-1){1'b0}}};

  // adder operand selection
  always_comb begin
    ax = a; ay = r; aci = 1'b0;
    unique case (op)
      OP_ADDC:         aci = c_in;
      OP_SUB, OP_CMP:  begin ay = ~r; aci = 1'b1; end
      OP_SUBC:         begin ay = ~r; aci = c_in; end
      OP_RSUB:         begin ax = r; ay = ~a; aci = 1'b1; end
      OP_NEG:          begin ax = '0; ay = ~a; aci = 1'b1; end
      default: ;
    endcase
  end

  assign sum = {1'b0, ax} + {1'b0, ay} + {{W{1'b0}}, aci};
  assign ovf = (ax[W-1] == ay[W-1]) && (sum[W-1] != ax[W-1]);

  assign sh     = lit[SHW-1:0];
  assign rot    = {a, a} << sh;
  assign shl_w  = {1'b0, a} << sh;
  assign shr_w  = {a, 1'b0} >> sh;
  assign sshr_w = $unsigned($signed({a, 1'b0}) >>> sh);
  assign ult    = a < r;
  assign slt    = $signed(a) < $signed(r);

  always_comb begin
    res = a; a_we = 1'b0; fval = a; zn_we = 1'b0;
    c_out = c_in; v_out = v_in;
    unique case (op)
      OP_LOAD, OP_SWAP: begin res = r; a_we = 1'b1; end
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_RSUB, OP_NEG: begin
        res = sum[W-1:0]; a_we = 1'b1; c_out = sum[W]; v_out = ovf;
      end
      OP_CMP: begin c_out = sum[W]; v_out = ovf; end
      OP_SETC: c_out = lit[0];
      OP_AND: begin res = a & r; a_we = 1'b1; v_out = 1'b0; end
      OP_OR:  begin res = a | r; a_we = 1'b1; v_out = 1'b0; end
      OP_XOR: begin res = a ^ r; a_we = 1'b1; v_out = 1'b0; end
      OP_SHL:  if (sh != '0) begin res = shl_w[W-1:0]; c_out = shl_w[W]; a_we = 1'b1; end
      OP_SHR:  if (sh != '0) begin res = shr_w[W:1]; c_out = shr_w[0]; a_we = 1'b1; end
      OP_SSHR: if (sh != '0) begin res = sshr_w[W:1]; c_out = sshr_w[0]; a_we = 1'b1; end
      OP_ROL:  if (sh != '0) begin res = rot[2*W-1:W]; c_out = rot[W]; a_we = 1'b1; end
      OP_UMIN: begin res = ult ? a : r; a_we = 1'b1; v_out = 1'b0; end
      OP_SMIN: begin res = slt ? a : r; a_we = 1'b1; v_out = 1'b0; end
      OP_UMAX: begin res = ult ? r : a; a_we = 1'b1; v_out = 1'b0; end
      OP_SMAX: begin res = slt ? r : a; a_we = 1'b1; v_out = 1'b0; end
      OP_ABS: begin
        res = a[W-1] ? (~a + 1'b1) : a; a_we = 1'b1; v_out = (a == SMIN_VAL);
      end
      default: ;
    endcase
    // flag value source: CMP uses difference, others the new A
    if (op == OP_CMP) begin
      fval = sum[W-1:0]; zn_we = 1'b1;
    end else if (op == OP_SHL || op == OP_SHR || op == OP_SSHR || op == OP_ROL) begin
      fval = res; zn_we = 1'b1;
    end else if (a_we) begin
      fval = res; zn_we = 1'b1;
    end
  end
endmodule

// File: rtl/acu_top.sv
module acu_top
  import acu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NREGS  = 256,
  parameter int BUS_W  = 8,
  parameter int ADDR_W = 5,
  localparam int IDX_W = $clog2(NREGS),
  localparam int NBYTE = DATA_W / BUS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata
);
  logic [DATA_W-1:0] acc, stage, rf_rd, rf_wd, alu_res, alu_fval;
  logic [IDX_W-1:0]  xidx, rf_wa;
  logic              rf_we, alu_awe, alu_znwe, alu_c, alu_v;
  logic              fc, fz, fn, fv, busy, err;
  logic              take;
  acu_op_e           op;

  assign op   = acu_op_e'(bus_addr);
  assign take = bus_wr && !busy;

  acu_regfile #(.WIDTH(DATA_W), .DEPTH(NREGS)) u_rf (
    .clk(clk), .we(rf_we), .waddr(rf_wa), .wdata(rf_wd),
    .raddr(bus_wdata[IDX_W-1:0]), .rdata(rf_rd)
  );

  acu_alu #(.W(DATA_W)) u_alu (
    .op(op), .a(acc), .r(rf_rd), .lit(bus_wdata), .c_in(fc), .v_in(fv),
    .res(alu_res), .a_we(alu_awe), .fval(alu_fval), .zn_we(alu_znwe),
    .c_out(alu_c), .v_out(alu_v)
  );

  always_comb begin
    rf_we = 1'b0; rf_wa = bus_wdata[IDX_W-1:0]; rf_wd = acc;
    if (take) begin
      if (op == OP_STORE || op == OP_SWAP) rf_we = 1'b1;
      else if (op == OP_XSAVE) begin rf_we = 1'b1; rf_wa = xidx; rf_wd = stage; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0; fc <= 1'b0; fz <= 1'b0; fn <= 1'b0; fv <= 1'b0;
      busy <= 1'b0; err <= 1'b0; stage <= '0; xidx <= '0;
    end else begin
      busy <= take;
      if (bus_wr && busy) err <= 1'b1;
      else if (bus_rd && bus_addr == '0) err <= 1'b0;
      if (take) begin
        if (alu_awe) acc <= alu_res;
        fc <= alu_c;
        fv <= alu_v;
        if (alu_znwe) begin
          fz <= (alu_fval == '0);
          fn <= alu_fval[DATA_W-1];
        end
        if (op == OP_XSEL) begin
          xidx  <= bus_wdata[IDX_W-1:0];
          stage <= rf_rd;
        end else if (op == OP_XPUT) begin
          stage <= {bus_wdata, stage[DATA_W-1:BUS_W]};
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == '0) begin
      bus_rdata[ST_C] = fc; bus_rdata[ST_Z] = fz; bus_rdata[ST_BUSY] = busy;
      bus_rdata[ST_ERR] = err; bus_rdata[ST_V] = fv; bus_rdata[ST_N] = fn;
    end else begin
      for (int i = 0; i < NBYTE; i++)
        if (int'(bus_addr) == i + 1) bus_rdata = stage[i*BUS_W +: BUS_W];
    end
  end

  AST_BUSY_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> busy && !$past(busy)); // R11
  AST_DROP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && busy) |=> err && acc == $past(acc)); // R11
  AST_CMP_KEEPS_ACC: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_CMP) |=> acc == $past(acc)); // R3
  AST_STORE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_STORE) |=> {fc, fz, fn, fv} == $past({fc, fz, fn, fv})); // R1
  AST_LOGIC_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op == OP_AND || op == OP_OR || op == OP_XOR)) |=> !fv && fc == $past(fc)); // R6
  AST_SHIFT_ZERO_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (take && (op == OP_SHL || op == OP_SHR || op == OP_SSHR || op == OP_ROL)
     && bus_wdata[4:0] == 5'd0) |=> acc == $past(acc) && fc == $past(fc)); // R7
  AST_SETC_ONLY_C: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == OP_SETC) |=> acc == $past(acc) && fv == $past(fv) && fz == $past(fz)); // R4
endmodule

// File: tb/acu_top_test.sv
module acu_top_test;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
  logic [4:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  int checks = 0, failures = 0;

  always #2.5 clk = ~clk;

  acu_top uut (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
               .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  logic [31:0] m_reg [256];
  logic [31:0] m_a;
  logic m_c, m_z, m_n, m_v, m_err;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd(input logic [4:0] a, output logic [7:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a; #1 v = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  function automatic logic [7:0] m_status();
    return {m_n, m_v, m_err, 1'b0, 2'b00, m_z, m_c};
  endfunction

  task automatic zn(input logic [31:0] x);
    m_z = (x == 0); m_n = x[31];
  endtask

  task automatic m_arith(input logic [31:0] x, input logic [31:0] y, input logic ci,
                         input logic wr);
    logic [32:0] s;
    s = {1'b0, x} + {1'b0, y} + {32'b0, ci};
    m_c = s[32];
    m_v = (x[31] == y[31]) && (s[31] != x[31]);
    zn(s[31:0]);
    if (wr) m_a = s[31:0];
  endtask

  task automatic model(input int op, input logic [7:0] d);
    logic [31:0] r, t;
    int n;
    r = m_reg[d]; n = d[4:0];
    case (op)
      0: begin m_a = r; zn(m_a); end
      1: m_reg[d] = m_a;
      2: begin m_reg[d] = m_a; m_a = r; zn(m_a); end
      3: m_arith(m_a, r, 1'b0, 1'b1);
      4: m_arith(m_a, r, m_c, 1'b1);
      5: m_arith(m_a, ~r, 1'b1, 1'b1);
      6: m_arith(m_a, ~r, m_c, 1'b1);
      7: m_arith(r, ~m_a, 1'b1, 1'b1);
      8: m_arith(m_a, ~r, 1'b1, 1'b0);
      9: m_c = d[0];
      10: m_arith(32'd0, ~m_a, 1'b1, 1'b1);
      11: begin m_a = m_a & r; m_v = 0; zn(m_a); end
      12: begin m_a = m_a | r; m_v = 0; zn(m_a); end
      13: begin m_a = m_a ^ r; m_v = 0; zn(m_a); end
      14: begin if (n != 0) begin m_c = m_a[32-n]; m_a = m_a << n; end zn(m_a); end
      15: begin if (n != 0) begin m_c = m_a[n-1]; m_a = m_a >> n; end zn(m_a); end
      16: begin if (n != 0) begin m_c = m_a[n-1]; m_a = $signed(m_a) >>> n; end zn(m_a); end
      17: begin
        for (int i = 0; i < n; i++) m_a = {m_a[30:0], m_a[31]};
        if (n != 0) m_c = m_a[0];
        zn(m_a);
      end
      18: begin m_a = (m_a < r) ? m_a : r; m_v = 0; zn(m_a); end
      19: begin m_a = ($signed(m_a) < $signed(r)) ? m_a : r; m_v = 0; zn(m_a); end
      20: begin m_a = (m_a > r) ? m_a : r; m_v = 0; zn(m_a); end
      21: begin m_a = ($signed(m_a) > $signed(r)) ? m_a : r; m_v = 0; zn(m_a); end
      22: begin
        m_v = (m_a == 32'h8000_0000);
        t = m_a[31] ? -m_a : m_a; m_a = t; zn(m_a);
      end
      default: ;
    endcase
  endtask

  task automatic do_op(input int op, input logic [7:0] d);
    model(op, d);
    cmd(op[4:0], d);
  endtask

  function automatic string req_of(input int op);
    case (op)
      0, 1, 2: return "R1";
      3, 4: return "R2";
      5, 6, 7, 8: return "R3";
      9: return "R4";
      10, 22: return "R5";
      11, 12, 13: return "R6";
      14, 15, 16, 17: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic put_reg(input logic [7:0] idx, input logic [31:0] v);
    cmd(5'd24, idx);
    for (int b = 0; b < 4; b++) cmd(5'd25, v[b*8 +: 8]);
    cmd(5'd26, 8'd0);
    m_reg[idx] = v;
  endtask

  task automatic check_acc(input string req);
    logic [31:0] got;
    logic [7:0] b;
    do_op(1, 8'd255);
    cmd(5'd24, 8'd255);
    for (int i = 0; i < 4; i++) begin rd(5'(i + 1), b); got[i*8 +: 8] = b; end
    chk(req, got, m_a);
  endtask

  task automatic check_status(input string req);
    logic [7:0] s;
    rd(5'd0, s);
    chk(req, {24'b0, s}, {24'b0, m_status()});
    m_err = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] s;
    void'($urandom(32'd1234));
    m_a = 0; m_c = 0; m_z = 0; m_n = 0; m_v = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R13: reset state
    rd(5'd0, s); chk("R13 status", {24'b0, s}, 32'd0);
    for (int i = 1; i <= 4; i++) begin
      rd(5'(i), s); chk("R13 stage", {24'b0, s}, 32'd0);
    end
    // R12: fill register file through the transfer port
    for (int i = 0; i < 256; i++) put_reg(8'(i), $urandom());
    put_reg(8'd1, 32'h8000_0000);
    put_reg(8'd2, 32'h7fff_ffff);
    put_reg(8'd3, 32'h0000_0001);
    put_reg(8'd4, 32'h0000_0000);
    put_reg(8'd5, 32'hffff_ffff);
    cmd(5'd24, 8'd2);
    for (int i = 0; i < 4; i++) begin
      rd(5'(i + 1), s); chk("R12 readback", {24'b0, s}, {24'b0, m_reg[2][i*8 +: 8]});
    end
    // R2: signed overflow and carry out
    do_op(0, 8'd2); do_op(3, 8'd3); check_status("R2 ovf"); check_acc("R2 sum");
    do_op(0, 8'd5); do_op(3, 8'd3); check_status("R2 carry zero"); check_acc("R2 wrap");
    // R5: negate and abs of most negative value
    do_op(0, 8'd1); do_op(10, 8'd0); check_status("R5 neg min"); check_acc("R5 neg min");
    do_op(0, 8'd4); do_op(10, 8'd0); check_status("R5 neg zero");
    do_op(0, 8'd1); do_op(22, 8'd0); check_status("R5 abs min"); check_acc("R5 abs min");
    // R3: compare leaves A, borrow sense
    do_op(0, 8'd4); do_op(8, 8'd3); check_status("R3 cmp borrow"); check_acc("R3 cmp keeps A");
    // R4 and R7: count 0 and 32 keep A and C
    do_op(0, 8'd2); do_op(9, 8'd1); check_status("R4 setc");
    do_op(14, 8'd0); check_status("R7 count0"); check_acc("R7 count0");
    do_op(17, 8'd32); check_status("R7 count32"); check_acc("R7 count32");
    do_op(9, 8'd2); check_status("R4 bit0 only");
    // R11: busy bit and dropped write
    do_op(0, 8'd3);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 5'd0; bus_wdata = 8'd2;
    @(negedge clk); bus_wr = 1'b0; bus_rd = 1'b1; bus_addr = 5'd0; #1 s = bus_rdata;
    chk("R11 busy", {31'b0, s[4]}, 32'd1);
    @(negedge clk); bus_rd = 1'b0;
    model(0, 8'd2);
    @(negedge clk); bus_wr = 1'b1; bus_addr = 5'd0; bus_wdata = 8'd5;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 5'd3; bus_wdata = 8'd5;
    @(negedge clk); bus_wr = 1'b0;
    @(negedge clk);
    model(0, 8'd5); m_err = 1'b1;
    rd(5'd0, s); chk("R11 err set", {24'b0, s}, {24'b0, m_status()});
    m_err = 1'b0;
    rd(5'd0, s); chk("R11 err cleared", {24'b0, s}, {24'b0, m_status()});
    check_acc("R11 dropped write");
    // R9 STORE keeps Z/N: covered by check_acc status afterwards
    check_status("R9 store flags");
    // random mix
    for (int it = 0; it < 400; it++) begin
      int op;
      logic [7:0] d;
      op = $urandom_range(0, 22);
      d = (it % 4 == 0) ? 8'($urandom_range(0, 5)) : 8'($urandom_range(0, 254));
      if (op == 14 || op == 15 || op == 16 || op == 17) d = 8'($urandom_range(0, 40));
      do_op(op, d);
      check_status({req_of(op), " R9 R10 flags"});
      check_acc({req_of(op), " result"});
    end
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule